// File: doc/BRIEF.md
# VGA-Style Palette Access Controller

This block keeps two colour lookup tables. Each table has 256 entries of 24 bits, 8 bits for each of red, green and blue. A host reaches the tables through a narrow 8-bit register port and uses the familiar sequential protocol. The host first loads an index. It then moves three bytes through a single data register, one colour component at a time. The block steps through the components by itself and moves on to the next entry after each blue byte. A red or green byte written by the host is held in a pending register. The table entry is written only when the blue byte arrives.

A second, independent port serves the video pipeline. Each cycle it takes a pixel index, ANDs it with a host-programmable mask, and returns the 24-bit colour one clock later. The host table and the display table are chosen by separate control bits. This lets software edit one table while the other is on screen. An optional 6-bit compatibility width scales values up by 2 bits on the way into a table and down by 2 bits on the way out. A status register exposes the access state. Another control bit changes what the read-index register returns.

Top module: `pal_access_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following hold. The index reads 0. The mode is write. The colour is red, so status reads 0x01. The mask reads 0xFF. The control register reads 0x00. The pending red byte reads 0x00. While reset is held, the display output is 0.
- R2: A host write to address 0 does three things: it sets write mode, loads the index with the written byte, and makes red the next colour. A host read of address 0 returns the current index.
- R3: A host write to address 1 does three things: it sets read mode, loads the index with the written byte plus one (0xFF gives 0x00), and makes red the next colour.
- R4: A data write (address 2) while the colour is red or green only stores the byte. Red goes to the pending red register, readable at address 6, and green to the pending green register, readable at address 7. The tables stay unchanged. A data write while the colour is blue writes the entry at the current index of the host table. The entry is {pending red, pending green, written byte}.
- R5: A data read (address 2) returns one component of the host-table entry at index minus one. Red gives bits 23:16, green gives bits 15:8 and blue gives bits 7:0.
- R6: Every data access, read or write, moves the colour from red to green, green to blue and blue to red. The index goes up by one only on the blue-to-red step, and wraps from 255 to 0.
- R7: The status register (address 5) is read-only. Bits 2:0 hold the colour one-hot: 1 for red, 2 for green, 4 for blue. Bits 5:4 hold the mode: 0 for write, 3 for read. All other bits read 0. A write to address 5 has no effect.
- R8: Control bit 0 selects the table used by host data accesses. Control bit 1 selects the table used by the display port. The two bits act independently. The control register is at address 4 and uses bits 3:0.
- R9: When control bit 2 is set, each byte is shifted left by 2 when a colour is written to a table, and the value returned by a data read is shifted right by 2. When the bit is clear, values pass through unchanged.
- R10: The display output is registered. One cycle after a pixel index is applied, the output holds the entry at (index AND mask) of the display table, packed as {red, green, blue}. The mask is at address 3.
- R11: With control bit 3 clear, a read of address 1 returns the current index. With control bit 3 set, it returns the mode in bits 1:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 3 | Host register address |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access; ignored while hst_wr is high |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational from the address and state |
| dsp_idx | input | 8 | Pixel index from the video pipeline |
| dsp_rgb | output | 24 | Registered colour for the previous cycle's pixel index |

## Verification
The bench fills both tables through the protocol using two different arithmetic patterns. This separates a bad table select from a bad component order. It reads every entry back through the read-index path, which exposes off-by-one errors in the index-minus-one addressing and the wrap at 255. Display sweeps cover all 256 indices, once with a full mask and once with a 4-bit mask, and these catch mask and select mistakes. Directed sequences check several things: that a partial red/green write leaves the table untouched, that the index wraps in both modes, that the 2-bit scaling drops the upper bits, and both read-index return choices.

// File: rtl/pal_pkg.sv
// Shared types and register addresses of the palette access controller.
package pal_pkg;
    // Next colour component expected by the data register, one-hot.
    typedef enum logic [2:0] {
        CLR_RED = 3'b001,
        CLR_GRN = 3'b010,
        CLR_BLU = 3'b100
    } clr_e;

    // Host access direction; the field is two bits wide.
    typedef enum logic [1:0] {
        ACC_WRITE = 2'b00,
        ACC_READ  = 2'b11
    } acc_mode_e;

    localparam logic [2:0] REG_WIDX   = 3'd0;
    localparam logic [2:0] REG_RIDX   = 3'd1;
    localparam logic [2:0] REG_DATA   = 3'd2;
    localparam logic [2:0] REG_MASK   = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;
    localparam logic [2:0] REG_STAT   = 3'd5;
    localparam logic [2:0] REG_PEND_R = 3'd6;
    localparam logic [2:0] REG_PEND_G = 3'd7;

    // Bit positions inside the control register.
    localparam int CTL_HSEL = 0;
    localparam int CTL_DSEL = 1;
    localparam int CTL_VGA  = 2;
    localparam int CTL_RBK  = 3;
    localparam int CTL_W    = 4;
endpackage

// File: rtl/pal_scale.sv
// Optional fixed shift of one colour component.
// UP=1 builds the store-side left shift; UP=0 builds the read-side right shift.
// Assumes SH < W.
module pal_scale #(
    parameter int W  = 8,
    parameter int SH = 2,
    parameter bit UP = 1'b1
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (UP) begin : g_up
            // Scale toward the top of the byte when the narrow width is on.
            assign dout = en ? (din << SH) : din;
        end else begin : g_down
            // Drop the low bits when the narrow width is on.
            assign dout = en ? (din >> SH) : din;
        end
    endgenerate
endmodule

// File: rtl/pal_seq.sv
// Sequential access state: index, mode, next colour and the pending red/green bytes.
// Index loads take priority over data accesses. The caller guarantees that
// a load and a data access never occur in the same cycle.
module pal_seq
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_wr,
    input  logic             ld_rd,
    input  logic [IDX_W-1:0] ld_val,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [CW-1:0]    dat_val,
    output logic [IDX_W-1:0] idx,
    output clr_e             clr,
    output acc_mode_e        mode,
    output logic [CW-1:0]    pend_r,
    output logic [CW-1:0]    pend_g,
    output logic             commit
);
    // An entry is written only when the blue byte arrives.
    assign commit = dat_wr && (clr == CLR_BLU);

    // Update the state on index loads and on data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            clr    <= CLR_RED;
            mode   <= ACC_WRITE;
            pend_r <= '0;
            pend_g <= '0;
        end else if (ld_wr) begin
            idx  <= ld_val;
            clr  <= CLR_RED;
            mode <= ACC_WRITE;
        end else if (ld_rd) begin
            idx  <= ld_val + IDX_W'(1);
            clr  <= CLR_RED;
            mode <= ACC_READ;
        end else if (dat_wr || dat_rd) begin
            case (clr)
                CLR_RED: begin
                    clr <= CLR_GRN;
                    if (dat_wr) pend_r <= dat_val;
                end
                CLR_GRN: begin
                    clr <= CLR_BLU;
                    if (dat_wr) pend_g <= dat_val;
                end
                default: begin
                    clr <= CLR_RED;
                    idx <= idx + IDX_W'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/pal_ram.sv
// Bank of NPAL colour tables with one write port, one asynchronous host read port
// and one registered display read port. Table contents are not reset.
// Assumes NPAL >= 2.
module pal_ram #(
    parameter int NPAL  = 2,
    parameter int IDX_W = 8,
    parameter int EW    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [IDX_W-1:0] waddr,
    input  logic [EW-1:0]    wdata,
    input  logic [SEL_W-1:0] hsel,
    input  logic [IDX_W-1:0] haddr,
    output logic [EW-1:0]    hdata,
    input  logic [SEL_W-1:0] dsel,
    input  logic [IDX_W-1:0] daddr,
    output logic [EW-1:0]    dq
);
    localparam int SEL_W = $clog2(NPAL);
    localparam int DEPTH = 1 << IDX_W;

    logic [EW-1:0] bank_h [NPAL];
    logic [EW-1:0] bank_d [NPAL];

    generate
        for (genvar b = 0; b < NPAL; b++) begin : g_bank
            logic [EW-1:0] mem [DEPTH];

            // Write the selected table.
            always_ff @(posedge clk) begin
                if (we && (wsel == SEL_W'(b))) mem[waddr] <= wdata;
            end

            assign bank_h[b] = mem[haddr];
            assign bank_d[b] = mem[daddr];
        end
    endgenerate

    assign hdata = bank_h[hsel];

    // Register the display lookup for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) dq <= '0;
        else        dq <= bank_d[dsel];
    end
endmodule

// File: rtl/pal_access_ctrl.sv
// Dual colour-table controller with a VGA-style sequential host port and a
// registered display lookup port. Decodes the host register map, holds the
// mask and control registers, and applies the optional narrow-width scaling.
// The host strobes last one cycle. A read strobe is ignored while a write strobe is high.
module pal_access_ctrl
    import pal_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int CW     = 8,
    parameter int VGA_SH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hst_addr,
    input  logic             hst_wr,
    input  logic             hst_rd,
    input  logic [CW-1:0]    hst_wdata,
    output logic [CW-1:0]    hst_rdata,
    input  logic [IDX_W-1:0] dsp_idx,
    output logic [3*CW-1:0]  dsp_rgb
);
    localparam int NPAL = 2;
    localparam int EW   = 3 * CW;

    logic             ld_wr, ld_rd, dat_wr, dat_rd, commit;
    logic [IDX_W-1:0] acc_idx;
    clr_e             acc_clr;
    acc_mode_e        acc_mode;
    logic [CW-1:0]    pend_r, pend_g;
    logic [IDX_W-1:0] mask_q;
    logic [CTL_W-1:0] ctrl_q;
    logic [EW-1:0]    host_ent;
    logic [CW-1:0]    comp_raw, comp_out;
    logic [CW-1:0]    st_r, st_g, st_b;
    logic [CW-1:0]    stat_val;

    // Decode the host strobes into register actions.
    assign ld_wr  = hst_wr && (hst_addr == REG_WIDX);
    assign ld_rd  = hst_wr && (hst_addr == REG_RIDX);
    assign dat_wr = hst_wr && (hst_addr == REG_DATA);
    assign dat_rd = hst_rd && !hst_wr && (hst_addr == REG_DATA);

    pal_seq #(.IDX_W(IDX_W), .CW(CW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_wr   (ld_wr),
        .ld_rd   (ld_rd),
        .ld_val  (hst_wdata[IDX_W-1:0]),
        .dat_wr  (dat_wr),
        .dat_rd  (dat_rd),
        .dat_val (hst_wdata),
        .idx     (acc_idx),
        .clr     (acc_clr),
        .mode    (acc_mode),
        .pend_r  (pend_r),
        .pend_g  (pend_g),
        .commit  (commit)
    );

    // Mask and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            ctrl_q <= '0;
        end else if (hst_wr) begin
            if (hst_addr == REG_MASK) mask_q <= hst_wdata[IDX_W-1:0];
            if (hst_addr == REG_CTRL) ctrl_q <= hst_wdata[CTL_W-1:0];
        end
    end

    // Scale the three components on their way into a table.
    pal_scale #(.W(CW), .SH(VGA_SH), .UP(1'b1)) u_up_r (
        .en(ctrl_q[CTL_VGA]), .din(pend_r), .dout(st_r));
    pal_scale #(.W(CW), .SH(VGA_SH), .UP(1'b1)) u_up_g (
        .en(ctrl_q[CTL_VGA]), .din(pend_g), .dout(st_g));
    pal_scale #(.W(CW), .SH(VGA_SH), .UP(1'b1)) u_up_b (
        .en(ctrl_q[CTL_VGA]), .din(hst_wdata), .dout(st_b));

    pal_ram #(.NPAL(NPAL), .IDX_W(IDX_W), .EW(EW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .wsel  (ctrl_q[CTL_HSEL]),
        .waddr (acc_idx),
        .wdata ({st_r, st_g, st_b}),
        .hsel  (ctrl_q[CTL_HSEL]),
        .haddr (acc_idx - IDX_W'(1)),
        .hdata (host_ent),
        .dsel  (ctrl_q[CTL_DSEL]),
        .daddr (dsp_idx & mask_q),
        .dq    (dsp_rgb)
    );

    // Pick the component that the next data read returns.
    always_comb begin
        case (acc_clr)
            CLR_RED: comp_raw = host_ent[3*CW-1:2*CW];
            CLR_GRN: comp_raw = host_ent[2*CW-1:CW];
            default: comp_raw = host_ent[CW-1:0];
        endcase
    end

    pal_scale #(.W(CW), .SH(VGA_SH), .UP(1'b0)) u_dn (
        .en(ctrl_q[CTL_VGA]), .din(comp_raw), .dout(comp_out));

    // Build the status byte: one-hot colour low, mode field above.
    always_comb begin
        stat_val      = '0;
        stat_val[2:0] = acc_clr;
        stat_val[5:4] = acc_mode;
    end

    // Host read-back multiplexer.
    always_comb begin
        case (hst_addr)
            REG_WIDX:   hst_rdata = CW'(acc_idx);
            REG_RIDX:   hst_rdata = ctrl_q[CTL_RBK] ? CW'(acc_mode) : CW'(acc_idx);
            REG_DATA:   hst_rdata = comp_out;
            REG_MASK:   hst_rdata = CW'(mask_q);
            REG_CTRL:   hst_rdata = CW'(ctrl_q);
            REG_STAT:   hst_rdata = stat_val;
            REG_PEND_R: hst_rdata = pend_r;
            default:    hst_rdata = pend_g;
        endcase
    end
endmodule

// File: rtl/pal_access_chk.sv
// Protocol checker for the access state, attached to the controller by bind.
// Observes the host strobes and the sequencer outputs.
module pal_access_chk
    import pal_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       hst_addr,
    input logic             hst_wr,
    input logic             hst_rd,
    input logic [CW-1:0]    hst_wdata,
    input logic [IDX_W-1:0] idx,
    input logic [2:0]       clr,
    input logic [1:0]       mode
);
    // R2: a write-index load sets the index, write mode and red.
    assert_widx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr == REG_WIDX) |=>
            (idx == $past(hst_wdata[IDX_W-1:0]) && mode == 2'b00 && clr == 3'b001));

    // R3: a read-index load sets the index plus one, read mode and red.
    assert_ridx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr == REG_RIDX) |=>
            (idx == IDX_W'($past(hst_wdata[IDX_W-1:0]) + 1'b1) && mode == 2'b11 && clr == 3'b001));

    // R6: the blue step returns to red and advances the index.
    assert_blue_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr == REG_DATA && (hst_wr || hst_rd) && clr == 3'b100) |=>
            (clr == 3'b001 && idx == IDX_W'($past(idx) + 1'b1)));

    // R6: red and green steps leave the index alone.
    assert_hold_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_addr == REG_DATA && (hst_wr || hst_rd) && clr != 3'b100) |=> $stable(idx));

    // R7: colour is one-hot and the mode takes only its two codes.
    assert_state_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(clr) == 1 && (mode == 2'b00 || mode == 2'b11)));
endmodule

bind pal_access_ctrl pal_access_chk #(.IDX_W(IDX_W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_addr  (hst_addr),
    .hst_wr    (hst_wr),
    .hst_rd    (hst_rd),
    .hst_wdata (hst_wdata),
    .idx       (acc_idx),
    .clr       (acc_clr),
    .mode      (acc_mode)
);

// File: tb/test_pal_access_ctrl.sv
`timescale 1ns/1ps
// Sweep bench: fills both tables, reads them back and scans the display port.
module test_pal_access_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [7:0]  wdat = '0;
    logic [7:0]  rdata;
    logic [7:0]  didx = '0;
    logic [23:0] rgb;

    int n_chk = 0;
    int n_fail = 0;
    logic [23:0] pal_m [2][256];

    always #10 clk = ~clk;

    pal_access_ctrl i_pal_access_ctrl (
        .clk(clk), .rst_n(rst_n), .hst_addr(addr), .hst_wr(wr), .hst_rd(rd),
        .hst_wdata(wdat), .hst_rdata(rdata), .dsp_idx(didx), .dsp_rgb(rgb));

    function automatic logic [23:0] pat(input int p, input int i);
        logic [7:0] b;
        b = 8'(i);
        if (p == 0) return {b, b ^ 8'h5A, ~b};
        return {b + 8'd7, 8'(b * 3), b ^ 8'hA5};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdat = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #2; d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic hrc(input string tag, input logic [2:0] a, input logic [7:0] e);
        logic [7:0] v;
        hr(a, v);
        chk(tag, v, e);
    endtask

    task automatic dchk(input string tag, input logic [7:0] i, input logic [23:0] e);
        @(negedge clk); didx = i;
        @(negedge clk); chk(tag, rgb, e);
    endtask

    task automatic fill(input int p);
        for (int i = 0; i < 256; i++) begin
            logic [23:0] e;
            e = pat(p, i);
            hw(3'd2, e[23:16]);
            hw(3'd2, e[15:8]);
            hw(3'd2, e[7:0]);
            pal_m[p][i] = e;
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        chk("R1 display during reset", rgb, 24'h0);
        rst_n = 1'b1;
        hrc("R1 index", 3'd0, 8'h00);
        hrc("R1 status", 3'd5, 8'h01);
        hrc("R1 mask", 3'd3, 8'hFF);
        hrc("R1 ctrl", 3'd4, 8'h00);
        hrc("R1 pending red", 3'd6, 8'h00);
        hw(3'd5, 8'hFF);
        hrc("R7 status write ignored", 3'd5, 8'h01);

        // Fill table 0 and then table 1 through the write protocol.
        hw(3'd4, 8'h00); hw(3'd0, 8'h00);
        fill(0);
        hrc("R6 index wrapped after 256 entries", 3'd0, 8'h00);
        hrc("R7 status red write", 3'd5, 8'h01);
        hw(3'd4, 8'h01); hw(3'd0, 8'h00);
        fill(1);

        // Display table 0 while host points at table 1.
        for (int i = 0; i < 256; i++) dchk("R10 display table0", 8'(i), pal_m[0][i]);
        // Display table 1 through a 4-bit mask, host on table 0.
        hw(3'd4, 8'h02); hw(3'd3, 8'h0F);
        hrc("R10 mask readback", 3'd3, 8'h0F);
        for (int i = 0; i < 256; i++) dchk("R8 R10 display table1 masked", 8'(i), pal_m[1][i & 15]);
        hw(3'd3, 8'hFF);

        // Read table 0 back entirely through the read-index path.
        hw(3'd1, 8'h00);
        hrc("R7 status read mode", 3'd5, 8'h31);
        for (int i = 0; i < 256; i++) begin
            hr(3'd2, v); chk("R5 read red", v, pal_m[0][i][23:16]);
            hr(3'd2, v); chk("R5 read green", v, pal_m[0][i][15:8]);
            hr(3'd2, v); chk("R5 read blue", v, pal_m[0][i][7:0]);
        end
        hrc("R6 read index wraps", 3'd0, 8'h01);

        // Upper half of table 1.
        hw(3'd4, 8'h01); hw(3'd1, 8'h80);
        for (int i = 128; i < 256; i++) begin
            hr(3'd2, v); chk("R8 read table1 red", v, pal_m[1][i][23:16]);
            hr(3'd2, v); chk("R8 read table1 green", v, pal_m[1][i][15:8]);
            hr(3'd2, v); chk("R8 read table1 blue", v, pal_m[1][i][7:0]);
        end

        // Read-index return choice.
        hw(3'd4, 8'h09);
        hrc("R11 mode on read-index, read", 3'd1, 8'h03);
        hw(3'd0, 8'h05);
        hrc("R11 mode on read-index, write", 3'd1, 8'h00);
        hw(3'd4, 8'h01);
        hrc("R11 index on read-index", 3'd1, 8'h05);
        hw(3'd1, 8'hFF);
        hrc("R3 read-index plus one wraps", 3'd0, 8'h00);

        // Partial entry must not reach the table.
        hw(3'd4, 8'h00); hw(3'd0, 8'h20);
        hrc("R2 index load", 3'd0, 8'h20);
        hw(3'd2, 8'hAB);
        hrc("R4 pending red", 3'd6, 8'hAB);
        hrc("R7 status green", 3'd5, 8'h02);
        dchk("R4 no commit after red", 8'h20, pal_m[0][8'h20]);
        hw(3'd2, 8'hCD);
        hrc("R4 pending green", 3'd7, 8'hCD);
        hrc("R7 status blue", 3'd5, 8'h04);
        dchk("R4 no commit after green", 8'h20, pal_m[0][8'h20]);
        hw(3'd2, 8'hEF);
        pal_m[0][8'h20] = 24'hABCDEF;
        dchk("R4 commit on blue", 8'h20, 24'hABCDEF);
        hrc("R6 index after entry", 3'd0, 8'h21);

        // Write-mode wrap at the top entry.
        hw(3'd0, 8'hFF);
        hw(3'd2, 8'h01); hw(3'd2, 8'h02); hw(3'd2, 8'h03);
        hrc("R6 write index wraps", 3'd0, 8'h00);
        dchk("R4 top entry written", 8'hFF, 24'h010203);

        // Narrow width: scale up on store, down on read.
        hw(3'd4, 8'h04); hw(3'd0, 8'h10);
        hw(3'd2, 8'h3F); hw(3'd2, 8'hC1); hw(3'd2, 8'hFF);
        dchk("R9 stored shifted left", 8'h10, 24'hFC04FC);
        hw(3'd1, 8'h10);
        hrc("R9 read red shifted right", 3'd2, 8'h3F);
        hrc("R9 read green shifted right", 3'd2, 8'h01);
        hrc("R9 read blue shifted right", 3'd2, 8'h3F);
        hw(3'd4, 8'h00); hw(3'd1, 8'h10);
        hrc("R9 full width read", 3'd2, 8'hFC);

        finish_run();
    end
endmodule